// File: doc/BRIEF.md
# GPIO Pad Interrupt Event Unit

This block watches a bank of general-purpose I/O pads and turns activity on them into interrupt events. Each pad takes its input through a two-stage synchronizer. A per-pad configuration word selects how the input is turned into an event: level, rising edge, both edges, or no capture at all. A per-pad inversion bit turns rising-edge capture into falling-edge capture and level capture into active-low capture. Events set sticky per-pad status bits. A per-pad enable mask selects which pending bits drive the single combined interrupt line.

Software reaches the block through a flat single-cycle register port. Address 0 holds the pending-status word, where writing 1 clears a bit. Address 1 holds the enable mask. Address 2 is a read-only pad value word. The upper half of the address space holds one configuration word per pad. The configuration word also holds the pad's direction controls, which go straight out as output-enable, input-enable and drive-value signals for the pad ring.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset every status and enable bit is 0, and `irq_o` is 0. Every pad configuration word reads 0x0A plus the synchronized input in bit 6: event capture is off, the output driver is disabled, and the input is enabled.
- R2: A pad input change set up before clock edge k reaches the synchronized sample at edge k+1. The status bit it causes is set at edge k+2 and not earlier.
- R3: Configuration bits [1:0] select the event mode. Code 0 is level, code 1 is rising edge, code 2 captures nothing, and code 3 is both edges. Edges are found by comparing the synchronized sample against the previous synchronized sample.
- R4: Configuration bit 2 inverts the synchronized input before detection. Edge mode with bit 2 set captures falling edges. Level mode with bit 2 set captures a low level. Changing bit 2 does not itself create an edge.
- R5: Address 0 reads the per-pad status word (bit i is pad i). A write to it clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R6: When a new event and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R7: In level mode the status bit is set in every cycle the inverted input is high, so it sets again after a clear while the level lasts.
- R8: Address 1 is the read/write enable mask. `irq_o` is high exactly when some pad is both pending and enabled. It follows a status or enable change in the cycle after the edge that made the change.
- R9: If a pending bit is cleared in an earlier cycle than its enable bit is set, no interrupt is raised at enable time. A later event on that pad raises the interrupt.
- R10: Configuration bit 3 disables the output driver (`pad_oe` = not bit 3), bit 4 disables the input buffer (`pad_ie` = not bit 4), and bit 5 is the driven value on `pad_do`.
- R11: Address 2 reads bit i as the drive value (bit 5) of pad i when its driver is enabled, and as the synchronized, non-inverted input otherwise. Writes to address 2 change nothing.
- R12: With the top address bit set, the low address bits select a pad's configuration word. Bits [5:0] are writable. Bit 6 reads the synchronized input and ignores writes. Bits above 6 read 0, and low-half addresses other than 0 to 2 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | NPADS | Raw pad inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NPADS)+1 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| pad_oe | output | NPADS | Output driver enable per pad |
| pad_ie | output | NPADS | Input buffer enable per pad |
| pad_do | output | NPADS | Drive value per pad |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong edge-history bit or mode decode shows up as a status bit that sets one cycle early, one cycle late, or on the wrong polarity. It can be seen at address 0 in the cycle after the faulty edge, and through `irq_o` at the same moment if the pad is enabled. A status bit that fails to clear, or that clears against a simultaneous event, is visible on the very next read. A corrupted configuration or enable register shows up at once on `pad_oe`, `pad_ie`, `pad_do` or `irq_o`. The bench keeps a behavioural model of every register and compares all outputs on every cycle. It also checks the two-cycle synchronizer latency at the exact edge.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    typedef enum logic [1:0] {
        EV_LEVEL = 2'd0,
        EV_RISE  = 2'd1,
        EV_OFF   = 2'd2,
        EV_BOTH  = 2'd3
    } ev_mode_e;

    typedef struct packed {
        logic     tx_state;
        logic     rx_off;
        logic     tx_off;
        logic     invert;
        ev_mode_e mode;
    } pad_cfg_t;

    localparam int CFG_W = $bits(pad_cfg_t);

    localparam pad_cfg_t CFG_RESET = '{
        tx_state: 1'b0,
        rx_off:   1'b0,
        tx_off:   1'b1,
        invert:   1'b0,
        mode:     EV_OFF
    };

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rx_sync,
    input  logic     invert,
    input  ev_mode_e mode,
    output logic     evt
);
    logic prev_q;
    logic cur_lvl;
    logic old_lvl;

    // history kept un-inverted so a polarity change makes no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= rx_sync;
    end

    assign cur_lvl = rx_sync ^ invert;
    assign old_lvl = prev_q ^ invert;

    always_comb begin
        unique case (mode)
            EV_LEVEL: evt = cur_lvl;
            EV_RISE:  evt = cur_lvl & ~old_lvl;
            EV_BOTH:  evt = cur_lvl ^ old_lvl;
            default:  evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] st_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr) | evt;
    end

    assert_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((st_q & $past(evt)) == $past(evt)));

    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~evt)) |=> ((st_q & $past(clr & ~evt)) == '0));
endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit
    import gpio_evt_pkg::*;
#(
    parameter int NPADS = 32,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPADS-1:0]         pad_in,
    input  logic                     reg_we,
    input  logic [$clog2(NPADS):0]   reg_addr,
    input  logic [DW-1:0]            reg_wdata,
    output logic [DW-1:0]            reg_rdata,
    output logic [NPADS-1:0]         pad_oe,
    output logic [NPADS-1:0]         pad_ie,
    output logic [NPADS-1:0]         pad_do,
    output logic                     irq_o
);
    localparam int IDX_W = $clog2(NPADS);
    localparam logic [IDX_W-1:0] A_STATUS = IDX_W'(0);
    localparam logic [IDX_W-1:0] A_ENABLE = IDX_W'(1);
    localparam logic [IDX_W-1:0] A_VALUE  = IDX_W'(2);

    logic [NPADS-1:0] rx_sync;
    logic [NPADS-1:0] evt;
    logic [NPADS-1:0] st_q;
    logic [NPADS-1:0] en_q;
    logic [NPADS-1:0] clr;
    logic [NPADS-1:0] value;
    pad_cfg_t         cfg_q [NPADS];

    logic             cfg_sel;
    logic [IDX_W-1:0] idx;

    assign cfg_sel = reg_addr[IDX_W];
    assign idx     = reg_addr[IDX_W-1:0];

    gpio_evt_sync #(.W(NPADS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (pad_in),
        .d_sync (rx_sync)
    );

    for (genvar i = 0; i < NPADS; i++) begin : g_pad
        logic cfg_we;
        assign cfg_we = reg_we & cfg_sel & (idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cfg_q[i] <= CFG_RESET;
            else if (cfg_we) cfg_q[i] <= pad_cfg_t'(reg_wdata[CFG_W-1:0]);
        end

        gpio_evt_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .rx_sync (rx_sync[i]),
            .invert  (cfg_q[i].invert),
            .mode    (cfg_q[i].mode),
            .evt     (evt[i])
        );

        assign pad_oe[i] = ~cfg_q[i].tx_off;
        assign pad_ie[i] = ~cfg_q[i].rx_off;
        assign pad_do[i] = cfg_q[i].tx_state;
        assign value[i]  = cfg_q[i].tx_off ? rx_sync[i] : cfg_q[i].tx_state;

        assert_off_mode_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[i].mode == EV_OFF && !st_q[i]) |=> !st_q[i]);
    end

    assign clr = (reg_we && !cfg_sel && idx == A_STATUS) ? reg_wdata[NPADS-1:0] : '0;

    gpio_evt_status #(.N(NPADS)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .clr   (clr),
        .st_q  (st_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '0;
        else if (reg_we && !cfg_sel && idx == A_ENABLE)
            en_q <= reg_wdata[NPADS-1:0];
    end

    assign irq_o = |(st_q & en_q);

    always_comb begin
        reg_rdata = '0;
        if (cfg_sel) begin
            for (int i = 0; i < NPADS; i++) begin
                if (idx == IDX_W'(i))
                    reg_rdata[CFG_W:0] = {rx_sync[i], cfg_q[i]};
            end
        end else begin
            case (idx)
                A_STATUS: reg_rdata[NPADS-1:0] = st_q;
                A_ENABLE: reg_rdata[NPADS-1:0] = en_q;
                A_VALUE:  reg_rdata[NPADS-1:0] = value;
                default:  reg_rdata = '0;
            endcase
        end
    end

    assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (st_q != $past(st_q)) || (en_q != $past(en_q)));
endmodule

// File: tb/gpio_evt_unit_test.sv
module gpio_evt_unit_test;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pad_in = '0;
    logic          reg_we = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  pad_oe, pad_ie, pad_do;
    logic          irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_evt_unit #(.NPADS(N), .DW(32)) uut (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_do(pad_do), .irq_o(irq_o)
    );

    // behavioural reference state
    logic [N-1:0] m_s1, m_s2, m_prev, m_st, m_en, m_inv, m_txoff, m_rxoff, m_txs;
    int           m_mode [N];
    logic [N-1:0] m_ev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_st = '0; m_en = '0;
            m_inv = '0; m_txoff = '1; m_rxoff = '0; m_txs = '0;
            foreach (m_mode[i]) m_mode[i] = 2;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit now_v, was_v;
                now_v = m_s2[i] ^ m_inv[i];
                was_v = m_prev[i] ^ m_inv[i];
                if (m_mode[i] == 0)      m_ev[i] = now_v;
                else if (m_mode[i] == 1) m_ev[i] = now_v && !was_v;
                else if (m_mode[i] == 3) m_ev[i] = now_v != was_v;
                else                     m_ev[i] = 1'b0;
            end
            if (reg_we && reg_addr == 6'd0) m_st = m_st & ~reg_wdata;
            m_st = m_st | m_ev;
            if (reg_we && reg_addr == 6'd1) m_en = reg_wdata;
            if (reg_we && reg_addr[5]) begin
                int k;
                k = int'(reg_addr[4:0]);
                m_mode[k]  = int'(reg_wdata[1:0]);
                m_inv[k]   = reg_wdata[2];
                m_txoff[k] = reg_wdata[3];
                m_rxoff[k] = reg_wdata[4];
                m_txs[k]   = reg_wdata[5];
            end
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    function automatic logic [31:0] exp_rd(logic [5:0] a);
        logic [31:0] r;
        int k;
        r = '0;
        if (a[5]) begin
            k = int'(a[4:0]);
            r[1:0] = 2'(m_mode[k]);
            r[2] = m_inv[k]; r[3] = m_txoff[k]; r[4] = m_rxoff[k];
            r[5] = m_txs[k]; r[6] = m_s2[k];
        end else if (a == 6'd0) r = m_st;
        else if (a == 6'd1) r = m_en;
        else if (a == 6'd2) begin
            for (int i = 0; i < N; i++) r[i] = m_txoff[i] ? m_s2[i] : m_txs[i];
        end
        return r;
    endfunction

    function automatic string rd_tag(logic [5:0] a);
        if (a[5]) return "R12";
        if (a == 6'd0) return "R5";
        if (a == 6'd1) return "R8";
        if (a == 6'd2) return "R11";
        return "R12";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N-1:0] oe_e;
            chk("R8 irq", {31'd0, irq_o}, {31'd0, |(m_st & m_en)});
            oe_e = ~m_txoff;
            chk("R10 oe", pad_oe, oe_e);
            chk("R10 ie", pad_ie, ~m_rxoff);
            chk("R10 do", pad_do, m_txs);
            chk(rd_tag(reg_addr), reg_rdata, exp_rd(reg_addr));
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [5:0] a, logic [31:0] mask, logic [31:0] exp);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata & mask, exp);
        tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        tick();
        rd_chk("R1 cfg", 6'h20, 32'hFFFF_FFFF, 32'h0A);
        rd_chk("R1 status", 6'h00, 32'hFFFF_FFFF, 32'h0);
        rd_chk("R1 enable", 6'h01, 32'hFFFF_FFFF, 32'h0);

        // R3 rising edge on pad 3
        wr(6'h23, 32'h09);
        pad_in[3] = 1'b1;
        repeat (4) tick();
        rd_chk("R3 rise", 6'h00, 32'h8, 32'h8);
        wr(6'h00, 32'h8);
        repeat (2) tick();
        rd_chk("R3 no re-arm", 6'h00, 32'h8, 32'h0);

        // R4 falling edge on pad 5 (edge + invert)
        wr(6'h25, 32'h0D);
        repeat (3) tick();
        rd_chk("R4 invert no edge", 6'h00, 32'h20, 32'h0);
        pad_in[5] = 1'b1;
        repeat (4) tick();
        rd_chk("R4 rise ignored", 6'h00, 32'h20, 32'h0);
        pad_in[5] = 1'b0;
        repeat (4) tick();
        rd_chk("R4 fall", 6'h00, 32'h20, 32'h20);
        wr(6'h00, 32'h20);

        // R3 both edges on pad 7
        wr(6'h27, 32'h0B);
        pad_in[7] = 1'b1;
        repeat (4) tick();
        rd_chk("R3 both rise", 6'h00, 32'h80, 32'h80);
        wr(6'h00, 32'h80);
        pad_in[7] = 1'b0;
        repeat (4) tick();
        rd_chk("R3 both fall", 6'h00, 32'h80, 32'h80);
        // R5 writing zero leaves bits
        wr(6'h00, 32'h0);
        rd_chk("R5 zero write", 6'h00, 32'h80, 32'h80);
        wr(6'h00, 32'h80);
        rd_chk("R5 clear", 6'h00, 32'h80, 32'h0);

        // R6/R7 level mode on pad 9
        wr(6'h29, 32'h08);
        pad_in[9] = 1'b1;
        repeat (4) tick();
        wr(6'h00, 32'h200);
        rd_chk("R6 event beats clear", 6'h00, 32'h200, 32'h200);
        repeat (3) tick();
        rd_chk("R7 level persists", 6'h00, 32'h200, 32'h200);
        pad_in[9] = 1'b0;
        repeat (4) tick();
        wr(6'h00, 32'h200);
        rd_chk("R7 level gone", 6'h00, 32'h200, 32'h0);

        // R4 active-low level on pad 10
        wr(6'h2A, 32'h0C);
        repeat (2) tick();
        rd_chk("R4 low level", 6'h00, 32'h400, 32'h400);
        wr(6'h2A, 32'h0A);
        wr(6'h00, 32'h400);
        rd_chk("R4 low cleared", 6'h00, 32'h400, 32'h0);

        // R2 exact latency on pad 14
        wr(6'h2E, 32'h09);
        reg_addr = 6'h00;
        pad_in[14] = 1'b1;
        tick(); tick();
        @(negedge clk);
        chk("R2 not yet", reg_rdata & 32'h4000, 32'h0);
        tick();
        @(negedge clk);
        chk("R2 set at k+2", reg_rdata & 32'h4000, 32'h4000);
        tick();
        wr(6'h00, 32'h4000);

        // R9 clear then enable, R8 later event
        wr(6'h2C, 32'h09);
        pad_in[12] = 1'b1;
        repeat (4) tick();
        wr(6'h00, 32'h1000);
        wr(6'h01, 32'h1000);
        @(negedge clk);
        chk("R9 no stale irq", {31'd0, irq_o}, 32'd0);
        tick();
        pad_in[12] = 1'b0;
        repeat (3) tick();
        pad_in[12] = 1'b1;
        repeat (4) tick();
        @(negedge clk);
        chk("R8 irq on event", {31'd0, irq_o}, 32'd1);
        tick();
        wr(6'h01, 32'h0);
        @(negedge clk);
        chk("R8 irq masked", {31'd0, irq_o}, 32'd0);
        tick();
        wr(6'h00, 32'h1000);

        // R10/R11 direction and value
        wr(6'h34, 32'h32);
        @(negedge clk);
        chk("R10 oe", {31'd0, pad_oe[20]}, 32'd1);
        chk("R10 ie", {31'd0, pad_ie[20]}, 32'd0);
        chk("R10 do", {31'd0, pad_do[20]}, 32'd1);
        tick();
        rd_chk("R11 tx value", 6'h02, 32'h10_0000, 32'h10_0000);
        wr(6'h02, 32'h0);
        wr(6'h34, 32'h0A);
        rd_chk("R11 rx value low", 6'h02, 32'h10_0000, 32'h0);
        pad_in[20] = 1'b1;
        repeat (3) tick();
        rd_chk("R11 rx value high", 6'h02, 32'h10_0000, 32'h10_0000);
        // R12 config word layout
        rd_chk("R12 rx bit", 6'h34, 32'hFFFF_FFFF, 32'h4A);
        wr(6'h35, 32'hFFFF_FF4A);
        rd_chk("R12 ro bits", 6'h35, 32'hFFFF_FFFF, 32'h0A);
        rd_chk("R12 hole", 6'h07, 32'hFFFF_FFFF, 32'h0);

        // mixed traffic against the model
        for (int c = 0; c < 3000; c++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0) pad_in = $urandom;
            else if (r[3:0] < 4'd4) pad_in[r[8:4]] = ~pad_in[r[8:4]];
            if (r[12:10] == 3'd0) begin
                reg_we = 1'b1;
                reg_addr = {r[13], 5'(r[18:14] % (r[13] ? 32 : 4))};
                reg_wdata = (reg_addr == 6'd1) ? $urandom : ($urandom & (r[19] ? 32'hFF : 32'hFFFF_FFFF));
            end else begin
                reg_we = 1'b0;
                reg_addr = r[25:20];
            end
            tick();
        end
        reg_we = 1'b0;
        tick();
        finish_run();
    end
endmodule